// File: doc/BRIEF.md
# Address Window Chip-Select Decoder

This block sits between the access source of an external bus controller and its pin-level sequencer. For every access it takes the 24-bit target address, matches it against four programmable address windows, and picks exactly one of five chip-select lines: one per window, plus a default line for addresses that no window covers. Along with the chip select it hands the sequencer that region's bus configuration: multiplexed or demultiplexed addressing, 8- or 16-bit data width, and a count of fixed wait states. The mode can therefore change from one access to the next.

Where windows overlap, a fixed hierarchy decides. The highest-numbered enabled window that contains the address wins. The block also masks the upper segment address lines down to a programmed count. It stretches an access beyond its fixed wait states for as long as a ready input, whose active level is programmable, stays inactive. Software loads all settings through a simple indexed register-write port. The decode result is latched when an access begins and held until that access completes.

Top module: `addr_window_csd`

## Requirements
- R1: Window register k (write index k-1, k = 1..4) holds the base in bits [23:12], an enable in bit 4 and a size code s in bits [3:0]. Codes above 11 act as 11. The window spans 4 KB << s bytes, aligned to that size: base bits below the size are ignored. A window with bit 4 clear never matches.
- R2: When several enabled windows contain the address, the one with the highest number is selected.
- R3: An address that no enabled window contains selects the default region: chip select bit 0 and configuration set 0.
- R4: While an access is in progress (busy high), exactly one bit of cs is high: bit k for window k, bit 0 for the default region. When idle, cs is all zero.
- R5: Configuration set j (write index 4 + j, j = 0..4, set j belonging to region j) holds multiplexed mode in bit 0, 16-bit width in bit 1, a wait-state count in bits [5:2] and a ready-enable in bit 6. During an access, the configuration outputs present the set of the selected region, so consecutive accesses to different regions present different modes.
- R6: A strobe on acc_start while idle starts an access in the next cycle. With the ready function disabled, the access lasts wait count + 1 cycles. acc_wait is high in every cycle except the last one, and acc_done is high in the last one only. busy falls after it.
- R7: The global register (write index 9) holds the ready active level in bit 0. When the selected set has ready enabled, once the wait count is used up the access goes on, with acc_wait high, until rdy_in equals the active level. With ready disabled, rdy_in has no effect.
- R8: Global register bits [4:1] hold the number n of active segment lines (values above 8 act as 8). bus_addr bits [15:0] follow the access address, bits 16+i follow it for i < n, and the other segment bits are zero.
- R9: The chip select, configuration and bus_addr are captured at the start of an access and stay stable until it completes. Neither a new strobe nor a register write during the access changes them.
- R10: After reset, all registers are zero: every window is disabled, every set has zero waits and ready disabled, and the segment count is 0. An access then takes the default chip select, finishes in one cycle and drives the segment bits to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_idx | input | 4 | Register index: 0-3 windows, 4-8 configuration sets, 9 global |
| reg_wdata | input | 24 | Register write data |
| acc_start | input | 1 | Access strobe, taken only when idle |
| acc_addr | input | 24 | Access address |
| rdy_in | input | 1 | Ready input, programmable active level |
| cs | output | 5 | Chip selects, active high, bit 0 default |
| bus_addr | output | 24 | Latched address with masked segment lines |
| cfg_mux | output | 1 | Selected region uses multiplexed mode |
| cfg_wide | output | 1 | Selected region uses 16-bit data |
| cfg_wait | output | 4 | Selected region's wait-state count |
| cfg_rdy_en | output | 1 | Selected region uses the ready input |
| busy | output | 1 | Access in progress |
| acc_wait | output | 1 | Access is being extended this cycle |
| acc_done | output | 1 | Last cycle of the access |

## Verification
The bench builds the block with its defaults: a 24-bit address, four windows, a 4 KB minimum size and eight segment lines. With these values, one address sweep of about six hundred points plus every window edge covers nested windows within a pair and across the pairs. Window sizes range from 4 KB to 8 MB, so both ends of the size code are exercised. Every segment count from 0 to the clamped value 9 is tried, along with both ready levels. An access is also disturbed mid-flight by a strobe and a register write.

// File: rtl/csd_pkg.sv
package csd_pkg;

   localparam int WAIT_W = 4;
   localparam int CFG_W  = WAIT_W + 3;

   // bit 0 mux, bit 1 wide, bits [WAIT_W+1:2] waits, top bit ready enable
   typedef struct packed {
      logic              rdy_en;
      logic [WAIT_W-1:0] waits;
      logic              wide;
      logic              mux;
   } bus_cfg_t;

endpackage

// File: rtl/csd_regs.sv
module csd_regs #(
   parameter int ADDR_W  = 24,
   parameter int NUM_WIN = 4,
   parameter int SEG_CW  = 4,
   parameter int IDX_W   = 4
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             we,
   input  logic [IDX_W-1:0]                 idx,
   input  logic [ADDR_W-1:0]                wdata,
   output logic [NUM_WIN-1:0][ADDR_W-1:0]   win_q,
   output csd_pkg::bus_cfg_t [NUM_WIN:0]    cfg_q,
   output logic                             rdy_level,
   output logic [SEG_CW-1:0]                seg_cnt
);
   import csd_pkg::*;

   localparam int CFG_BASE = NUM_WIN;
   localparam int GLB_IDX  = 2 * NUM_WIN + 1;

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_win
      always_ff @(posedge clk) begin
         if (!rst_n)
            win_q[k] <= '0;
         else if (we && idx == IDX_W'(k))
            win_q[k] <= wdata;
      end
   end

   for (genvar j = 0; j <= NUM_WIN; j++) begin : g_cfg
      always_ff @(posedge clk) begin
         if (!rst_n)
            cfg_q[j] <= '0;
         else if (we && idx == IDX_W'(CFG_BASE + j))
            cfg_q[j] <= bus_cfg_t'(wdata[CFG_W-1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdy_level <= 1'b0;
         seg_cnt   <= '0;
      end else if (we && idx == IDX_W'(GLB_IDX)) begin
         rdy_level <= wdata[0];
         seg_cnt   <= wdata[SEG_CW:1];
      end
   end

endmodule

// File: rtl/csd_win_match.sv
module csd_win_match #(
   parameter int ADDR_W  = 24,
   parameter int MIN_LOG = 12,
   parameter int SZ_W    = 4,
   parameter int EN_BIT  = 4
) (
   input  logic [ADDR_W-1:0] win_reg,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam int MAX_CODE = ADDR_W - 1 - MIN_LOG;

   logic [SZ_W-1:0]   code_c;
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] keep;

   always_comb begin
      code_c = (win_reg[SZ_W-1:0] > SZ_W'(MAX_CODE)) ? SZ_W'(MAX_CODE)
                                                     : win_reg[SZ_W-1:0];
      base   = {win_reg[ADDR_W-1:MIN_LOG], {MIN_LOG{1'b0}}};
      for (int i = 0; i < ADDR_W; i++)
         keep[i] = (i >= MIN_LOG + int'(code_c));
      hit = win_reg[EN_BIT] && (((addr ^ base) & keep) == '0);
   end

endmodule

// File: rtl/csd_prio.sv
module csd_prio #(
   parameter int NUM_WIN = 4,
   parameter int SEL_W   = 3
) (
   input  logic [NUM_WIN-1:0] hit,
   output logic [NUM_WIN:0]   sel,
   output logic [SEL_W-1:0]   sel_idx
);
   // ascending scan: a later (higher) window overwrites a lower one
   always_comb begin
      sel_idx = '0;
      for (int k = 0; k < NUM_WIN; k++)
         if (hit[k]) sel_idx = SEL_W'(k + 1);
      sel = '0;
      sel[sel_idx] = 1'b1;
   end

endmodule

// File: rtl/csd_seq.sv
module csd_seq #(
   parameter int ADDR_W = 24,
   parameter int NCS    = 5
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NCS-1:0]      cs_d,
   input  csd_pkg::bus_cfg_t   cfg_d,
   input  logic [ADDR_W-1:0]   addr_d,
   input  logic                rdy_in,
   input  logic                rdy_level,
   output logic                busy,
   output logic [NCS-1:0]      cs_q,
   output csd_pkg::bus_cfg_t   cfg_q,
   output logic [ADDR_W-1:0]   addr_q,
   output logic                wait_o,
   output logic                done_o
);
   import csd_pkg::*;

   logic [WAIT_W-1:0] cnt;
   logic              rdy_hold;

   assign rdy_hold = cfg_q.rdy_en && (rdy_in != rdy_level);
   assign wait_o   = busy && ((cnt != '0) || rdy_hold);
   assign done_o   = busy && !wait_o;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cs_q   <= '0;
         cfg_q  <= '0;
         addr_q <= '0;
         cnt    <= '0;
      end else if (!busy) begin
         if (start) begin
            busy   <= 1'b1;
            cs_q   <= cs_d;
            cfg_q  <= cfg_d;
            addr_q <= addr_d;
            cnt    <= cfg_d.waits;
         end
      end else if (done_o) begin
         busy <= 1'b0;
         cs_q <= '0;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/addr_window_csd.sv
module addr_window_csd #(
   parameter int ADDR_W  = 24,
   parameter int NUM_WIN = 4,
   parameter int MIN_LOG = 12,
   parameter int SZ_W    = 4,
   parameter int SEG_LO  = 16,
   localparam int NCS    = NUM_WIN + 1,
   localparam int IDX_W  = $clog2(2 * NUM_WIN + 2),
   localparam int WAIT_W = csd_pkg::WAIT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [IDX_W-1:0]  reg_idx,
   input  logic [ADDR_W-1:0] reg_wdata,
   input  logic              acc_start,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              rdy_in,
   output logic [NCS-1:0]    cs,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              cfg_mux,
   output logic              cfg_wide,
   output logic [WAIT_W-1:0] cfg_wait,
   output logic              cfg_rdy_en,
   output logic              busy,
   output logic              acc_wait,
   output logic              acc_done
);
   import csd_pkg::*;

   localparam int SEG_N  = ADDR_W - SEG_LO;
   localparam int SEG_CW = $clog2(SEG_N + 1);
   localparam int SEL_W  = $clog2(NCS);
   localparam int EN_BIT = SZ_W;

   if (MIN_LOG <= EN_BIT) begin : g_bad_min
      $error("MIN_LOG must leave room for the size code and enable bit");
   end
   if (ADDR_W - 1 - MIN_LOG >= (1 << SZ_W)) begin : g_bad_sz
      $error("SZ_W too narrow for the size range");
   end
   if (SEG_LO >= ADDR_W || SEG_CW >= ADDR_W) begin : g_bad_seg
      $error("segment field does not fit");
   end
   if (CFG_W > ADDR_W) begin : g_bad_cfg
      $error("configuration word wider than write data");
   end

   logic [NUM_WIN-1:0][ADDR_W-1:0] win_q;
   bus_cfg_t [NUM_WIN:0]           cfg_set;
   logic                           rdy_level_q;
   logic [SEG_CW-1:0]              seg_cnt_q;
   logic [NUM_WIN-1:0]             hit;
   logic [NCS-1:0]                 sel;
   logic [SEL_W-1:0]               sel_idx;
   bus_cfg_t                       cfg_d;
   bus_cfg_t                       cfg_q;
   logic [ADDR_W-1:0]              addr_m;

   csd_regs #(
      .ADDR_W (ADDR_W),
      .NUM_WIN(NUM_WIN),
      .SEG_CW (SEG_CW),
      .IDX_W  (IDX_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we       (reg_we),
      .idx      (reg_idx),
      .wdata    (reg_wdata),
      .win_q    (win_q),
      .cfg_q    (cfg_set),
      .rdy_level(rdy_level_q),
      .seg_cnt  (seg_cnt_q)
   );

   for (genvar k = 0; k < NUM_WIN; k++) begin : g_match
      csd_win_match #(
         .ADDR_W (ADDR_W),
         .MIN_LOG(MIN_LOG),
         .SZ_W   (SZ_W),
         .EN_BIT (EN_BIT)
      ) u_match (
         .win_reg(win_q[k]),
         .addr   (acc_addr),
         .hit    (hit[k])
      );
   end

   csd_prio #(
      .NUM_WIN(NUM_WIN),
      .SEL_W  (SEL_W)
   ) u_prio (
      .hit    (hit),
      .sel    (sel),
      .sel_idx(sel_idx)
   );

   assign cfg_d = cfg_set[sel_idx];

   assign addr_m[SEG_LO-1:0] = acc_addr[SEG_LO-1:0];
   for (genvar i = 0; i < SEG_N; i++) begin : g_seg
      assign addr_m[SEG_LO+i] = acc_addr[SEG_LO+i] && (seg_cnt_q >= SEG_CW'(i + 1));
   end

   csd_seq #(
      .ADDR_W(ADDR_W),
      .NCS   (NCS)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (acc_start),
      .cs_d     (sel),
      .cfg_d    (cfg_d),
      .addr_d   (addr_m),
      .rdy_in   (rdy_in),
      .rdy_level(rdy_level_q),
      .busy     (busy),
      .cs_q     (cs),
      .cfg_q    (cfg_q),
      .addr_q   (bus_addr),
      .wait_o   (acc_wait),
      .done_o   (acc_done)
   );

   assign cfg_mux    = cfg_q.mux;
   assign cfg_wide   = cfg_q.wide;
   assign cfg_wait   = cfg_q.waits;
   assign cfg_rdy_en = cfg_q.rdy_en;

endmodule

// File: rtl/addr_window_csd_chk.sv
module addr_window_csd_chk #(
   parameter int ADDR_W = 24,
   parameter int NCS    = 5,
   parameter int SEG_LO = 16,
   parameter int SEG_CW = 4,
   parameter int WAIT_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              acc_start,
   input logic [NCS-1:0]    cs,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              cfg_mux,
   input logic              cfg_wide,
   input logic [WAIT_W-1:0] cfg_wait,
   input logic              cfg_rdy_en,
   input logic              busy,
   input logic              acc_wait,
   input logic              acc_done,
   input logic              rdy_in,
   input logic              rdy_level,
   input logic [SEG_CW-1:0] seg_cnt
);

   a_r4_one_cs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> $countones(cs) == 1);

   a_r4_no_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> cs == '0);

   a_r6_done_ends: assert property (@(posedge clk) disable iff (!rst_n)
      acc_done |=> !busy);

   a_r6_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && acc_start) |=> busy);

   a_r6_wait_xor_done: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (acc_wait != acc_done));

   a_r7_ready_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cfg_rdy_en && rdy_in != rdy_level) |-> (acc_wait && !acc_done));

   a_r8_seg_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !$past(busy)) |->
         ((bus_addr[ADDR_W-1:SEG_LO] >> $past(seg_cnt)) == '0));

   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !acc_done) |=>
         ($stable(cs) && $stable(bus_addr) && $stable(cfg_mux) &&
          $stable(cfg_wide) && $stable(cfg_wait) && $stable(cfg_rdy_en)));

endmodule

bind addr_window_csd addr_window_csd_chk #(
   .ADDR_W(ADDR_W),
   .NCS   (NCS),
   .SEG_LO(SEG_LO),
   .SEG_CW(SEG_CW),
   .WAIT_W(WAIT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .acc_start (acc_start),
   .cs        (cs),
   .bus_addr  (bus_addr),
   .cfg_mux   (cfg_mux),
   .cfg_wide  (cfg_wide),
   .cfg_wait  (cfg_wait),
   .cfg_rdy_en(cfg_rdy_en),
   .busy      (busy),
   .acc_wait  (acc_wait),
   .acc_done  (acc_done),
   .rdy_in    (rdy_in),
   .rdy_level (rdy_level_q),
   .seg_cnt   (seg_cnt_q)
);

// File: tb/addr_window_csd_tb.sv
module addr_window_csd_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_idx = '0;
   logic [23:0] reg_wdata = '0;
   logic        acc_start = 1'b0;
   logic [23:0] acc_addr = '0;
   logic        rdy_in = 1'b0;
   logic [4:0]  cs;
   logic [23:0] bus_addr;
   logic        cfg_mux, cfg_wide, cfg_rdy_en, busy, acc_wait, acc_done;
   logic [3:0]  cfg_wait;

   int n_cmp = 0;
   int n_bad = 0;

   logic [23:0] wreg [4];
   logic [6:0]  creg [5];
   logic        lvl = 1'b0;
   int          segn = 0;

   always #10 clk = ~clk;

   addr_window_csd u_dut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_idx(reg_idx),
      .reg_wdata(reg_wdata), .acc_start(acc_start), .acc_addr(acc_addr),
      .rdy_in(rdy_in), .cs(cs), .bus_addr(bus_addr), .cfg_mux(cfg_mux),
      .cfg_wide(cfg_wide), .cfg_wait(cfg_wait), .cfg_rdy_en(cfg_rdy_en),
      .busy(busy), .acc_wait(acc_wait), .acc_done(acc_done)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int win_lo(input int k);
      int s, sz;
      s  = int'(wreg[k][3:0]);
      if (s > 11) s = 11;
      sz = 4096 << s;
      return (int'(wreg[k][23:12]) * 4096) / sz * sz;
   endfunction

   function automatic int win_sz(input int k);
      int s;
      s = int'(wreg[k][3:0]);
      if (s > 11) s = 11;
      return 4096 << s;
   endfunction

   function automatic int winner(input logic [23:0] a);
      int w, lo;
      w = 0;
      for (int k = 0; k < 4; k++) begin
         lo = win_lo(k);
         if (wreg[k][4] && int'(a) >= lo && int'(a) < lo + win_sz(k)) w = k + 1;
      end
      return w;
   endfunction

   function automatic logic [23:0] exp_bus(input logic [23:0] a);
      int n, hi;
      n  = (segn > 8) ? 8 : segn;
      hi = (int'(a) >> 16) & ((1 << n) - 1);
      return 24'((hi << 16) | (int'(a) & 32'hFFFF));
   endfunction

   task automatic wr(input int idx, input logic [23:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_idx = 4'(idx); reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic set_win(input int k, input logic [23:0] base, input bit en,
                          input int code);
      wreg[k] = {base[23:12], 7'd0, en, 4'(code)};
      wr(k, wreg[k]);
   endtask

   task automatic set_cfg(input int j, input bit re, input int ws, input bit wide,
                          input bit mux);
      creg[j] = {re, 4'(ws), wide, mux};
      wr(4 + j, {17'd0, creg[j]});
   endtask

   task automatic set_glob(input bit l, input int n);
      lvl = l; segn = n;
      wr(9, {19'd0, 4'(n), l});
   endtask

   task automatic access(input logic [23:0] a, input int stall, input bit poke);
      int w, ws, expn, got;
      bit re, ok_hold, ok_wait;
      logic [4:0] cs0;
      logic [23:0] ba0;
      w = winner(a);
      ws = int'(creg[w][5:2]);
      re = creg[w][6];
      expn = ws + (re ? stall : 0);
      got = -1; ok_hold = 1'b1; ok_wait = 1'b1;
      cs0 = '0; ba0 = '0;
      @(negedge clk);
      acc_addr = a; acc_start = 1'b1;
      @(negedge clk);
      acc_start = 1'b0;
      for (int n = 0; n < 64; n++) begin
         rdy_in = (n >= ws + stall) ? lvl : ~lvl;
         if (poke && n == 1) begin
            acc_start = 1'b1; acc_addr = ~a;
            reg_we = 1'b1; reg_idx = 4'd3; reg_wdata = 24'd0;
         end
         if (poke && n == 2) begin
            acc_start = 1'b0; reg_we = 1'b0; wreg[3] = 24'd0;
         end
         #1;
         if (n == 0) begin
            cs0 = cs; ba0 = bus_addr;
            chk(cs === 5'(1 << w), (w == 0) ? "R3 default cs" : "R1/R2 window cs",
                32'(cs), 32'(1 << w));
            chk({cfg_rdy_en, cfg_wait, cfg_wide, cfg_mux} === creg[w], "R5 config",
                32'({cfg_rdy_en, cfg_wait, cfg_wide, cfg_mux}), 32'(creg[w]));
            chk(bus_addr === exp_bus(a), "R8 bus_addr", 32'(bus_addr), 32'(exp_bus(a)));
         end else if (cs !== cs0 || bus_addr !== ba0) begin
            ok_hold = 1'b0;
         end
         if (acc_done === 1'b1) begin
            got = n;
            if (acc_wait !== 1'b0) ok_wait = 1'b0;
            break;
         end else if (acc_wait !== 1'b1) begin
            ok_wait = 1'b0;
         end
         @(negedge clk);
      end
      if (poke) begin
         acc_start = 1'b0; reg_we = 1'b0;
      end
      chk(got == expn, "R6/R7 access length", 32'(got), 32'(expn));
      chk(ok_wait, "R6 wait/done shape", 32'(ok_wait), 32'd1);
      chk(ok_hold, "R9 held during access", 32'(ok_hold), 32'd1);
      @(negedge clk);
      #1;
      chk(busy === 1'b0 && cs === 5'd0, "R4 idle after done", 32'({busy, cs}), 32'd0);
      rdy_in = lvl;
   endtask

   task automatic sweep();
      int lo, sz;
      for (int k = 0; k < 600; k++)
         access(24'(k * 32'h7FF1), 0, 1'b0);
      for (int k = 0; k < 4; k++) begin
         lo = win_lo(k); sz = win_sz(k);
         access(24'(lo - 1), 0, 1'b0);
         access(24'(lo), 0, 1'b0);
         access(24'(lo + sz - 1), 0, 1'b0);
         access(24'(lo + sz), 0, 1'b0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      for (int k = 0; k < 4; k++) wreg[k] = '0;
      for (int j = 0; j < 5; j++) creg[j] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R10: reset state and first access
      chk(cs === 5'd0 && busy === 1'b0 && acc_wait === 1'b0 && acc_done === 1'b0,
          "R10 reset outputs", 32'({cs, busy, acc_wait, acc_done}), 32'd0);
      access(24'h123456, 0, 1'b0);
      access(24'hFEDCBA, 5, 1'b0);

      set_glob(1'b1, 8);
      for (int j = 0; j < 5; j++) set_cfg(j, j == 4, j, j[0], ~j[0]);
      // nested within a pair and across pairs; W3 base has ignored low bits
      set_win(0, 24'h100000, 1'b1, 8);
      set_win(1, 24'h180000, 1'b1, 4);
      set_win(2, 24'h812000, 1'b1, 11);
      set_win(3, 24'h835000, 1'b1, 0);
      sweep();

      // R5: back-to-back accesses hitting differently configured regions
      access(24'h1A0000, 0, 1'b0);
      access(24'h181234, 0, 1'b0);
      access(24'h835ABC, 0, 1'b0);

      // R2: three nested windows, oversized code clamps
      set_win(2, 24'h182000, 1'b1, 1);
      set_win(3, 24'hF00000, 1'b1, 15);
      sweep();

      // R1: disabled window never matches
      set_win(1, 24'h180000, 1'b0, 4);
      set_win(3, 24'h835000, 1'b1, 0);
      sweep();

      // R8: every segment count, including the clamp
      for (int n = 0; n < 10; n++) begin
         set_glob(1'b1, n);
         access(24'hABCDEF, 0, 1'b0);
         access(24'h5A5A5A, 0, 1'b0);
      end

      // R7: ready stalls at both levels; ignored when disabled
      set_cfg(4, 1'b1, 2, 1'b1, 1'b0);
      set_glob(1'b1, 8);
      access(24'h835800, 3, 1'b0);
      set_glob(1'b0, 8);
      access(24'h835800, 3, 1'b0);
      access(24'h835800, 0, 1'b0);
      access(24'h150000, 4, 1'b0);

      // R9: strobe and register write during an access
      access(24'h835100, 6, 1'b1);
      access(24'h835100, 0, 1'b0);
      set_win(3, 24'h835000, 1'b1, 0);
      access(24'h835100, 0, 1'b0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule